// File: doc/BRIEF.md
# SDLC Serial Bit Processor

This block is the bit-level engine of a synchronous HDLC/SDLC serial link. It has a transmit half and a receive half. The transmit half accepts frame bytes over a valid/ready stream, appends a 16-bit frame check sequence and inserts stuffing zeros, then wraps each frame in flag bytes and drives an NRZI-coded serial line. The receive half works in reverse. It decodes the NRZI line and locates flags, strips stuffed zeros and rebuilds bytes, then checks the FCS. It reports the start of a frame, its end, an abort, a CRC failure or a length failure.

All serial activity advances only on cycles where `bit_en` is high. The bit clock can therefore come from an external serial clock that has been synchronised into an enable, or from an internal divider in a self-clocked arrangement. Between frames the transmitter sends flags without a break. When a new frame follows at once, the closing flag of one frame is also the opening flag of the next.

Transmit back-pressure works as follows. `tx_ready` is high when the one-byte holding register is free, and a byte moves across on every cycle where `tx_valid` and `tx_ready` are both high. Once a frame has started, the source must present the next byte before the last bit of the current byte leaves; if it does not, the frame is aborted. The receive stream has no back-pressure, because a serial line cannot be stalled. `rx_valid` is a one-cycle strobe and must be captured when it appears. Bytes received in a frame that ends with an error or an abort must be discarded by the consumer.

Top module: `sdlc_bitproc`

## Requirements
- R1: NRZI coding in both directions. A data 0 is a change of line level and a data 1 is no change. After reset `tx_line` is 1, `tx_ready` is 1 and every receive strobe is 0.
- R2: Bytes are serialized and deserialized least significant bit first. The receiver delivers the frame content bytes in order on `rx_valid`/`rx_data`, with the two FCS bytes removed.
- R3: Inside frame content, FCS included, the transmitter inserts a 0 after five consecutive 1s, including after the final FCS bit. The receiver deletes a 0 that follows five 1s. Outside an abort, the line never carries more than six consecutive data 1s.
- R4: The flag is 0x7E (bits 0,1,1,1,1,1,1,0 on the line, in that order) and is never stuffed. An idle transmitter sends flags continuously. The receiver pulses `rx_frame_start` when the first byte after a flag completes.
- R5: The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, computed bit-reflected (0x8408) with a preset of 0xFFFF. Its ones-complement is sent low byte first. On the closing flag the receiver pulses `rx_frame_end`, and also `rx_crc_err` if the register run over content plus FCS does not equal 0xF0B8.
- R6: Seven consecutive 1s on receive abort the frame. `rx_abort` pulses if a frame was open, no `rx_frame_end` follows, and the receiver ignores data until the next flag.
- R7: With `rx_frame_end`, `rx_len_err` pulses when fewer than two bytes completed, or when the frame did not end on a byte boundary. In that case `rx_crc_err` stays 0.
- R8: A byte is taken on `tx_valid && tx_ready`, after which `tx_ready` is 0 until the byte enters the shifter. A byte with `tx_last` = 1 closes the frame. If no byte is waiting at a byte boundary inside a frame, the transmitter sends eight 1s (an abort) and then flags.
- R9: With `bit_en` low, `tx_line` and all receive outputs hold, and no stored byte is consumed.
- R10: Frames sent back to back share one flag, and both are received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-period enable |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit holding register free |
| tx_data | input | 8 | Transmit byte |
| tx_last | input | 1 | Byte is the last of its frame |
| tx_line | output | 1 | NRZI serial output |
| rx_line | input | 1 | NRZI serial input |
| rx_valid | output | 1 | Received content byte strobe |
| rx_data | output | 8 | Received content byte |
| rx_frame_start | output | 1 | First byte of a frame completed |
| rx_frame_end | output | 1 | Closing flag seen on an open frame |
| rx_abort | output | 1 | Open frame aborted by seven 1s |
| rx_crc_err | output | 1 | FCS residue mismatch (with frame end) |
| rx_len_err | output | 1 | Short or misaligned frame (with frame end) |

## Verification
Some properties are checked by assertions on every cycle. The transmit run of 1s never passes five inside content. A handshake always drops `tx_ready`. The line holds while `bit_en` is low. An abort never coincides with a frame end, and a CRC error only appears with a frame end and never alongside a length error. Other behaviour can only be shown by the bench's scenarios, because it depends on whole bit sequences. These cover byte order and content after FCS removal, the residue check against a bench-computed FCS, the maximum run of 1s on the line, flag sharing between frames, underrun aborts, and the rejection of short or misaligned frames.

// File: rtl/sdlc_pkg.sv
package sdlc_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W  = 16;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [2:0] STUFF_RUN = 3'd5;
  localparam logic [2:0] FLAG_RUN  = 3'd6;
  localparam logic [2:0] RUN_MAX   = 3'd7;
  localparam logic [FCS_W-1:0] CRC_POLY_REV = 16'h8408;
  localparam logic [FCS_W-1:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [FCS_W-1:0] CRC_RESIDUE  = 16'hF0B8;

  typedef enum logic [1:0] {TX_FLAG, TX_DATA, TX_FCS, TX_ABORT} tx_state_e;

  function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[FCS_W-1:1]} ^ (fb ? CRC_POLY_REV : '0);
  endfunction

  function automatic logic [FCS_W-1:0] crc_octet(input logic [FCS_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
    logic [FCS_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) r = crc_step(r, d[i]);
    return r;
  endfunction
endpackage

// File: rtl/sdlc_tx.sv
module sdlc_tx
  import sdlc_pkg::*;
#(
  parameter int ABORT_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_last,
  output logic              dbit
);
  localparam int MAXC = (ABORT_BITS > FCS_W) ? ABORT_BITS : FCS_W;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] BYTE_END  = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] FCS_END   = CW'(FCS_W - 1);
  localparam logic [CW-1:0] FCS_TAIL  = CW'(FCS_W);
  localparam logic [CW-1:0] ABORT_END = CW'(ABORT_BITS - 1);

  tx_state_e         st;
  logic [CW-1:0]     bcnt;
  logic [2:0]        ones;
  logic [BYTE_W-1:0] sreg, hold_d;
  logic              sreg_last, hold_last, hold_full;
  logic [FCS_W-1:0]  crc, fcs;
  logic              stuff_now;
  logic [2:0]        ones_nx;
  logic [FCS_W-1:0]  crc_nx;

  assign tx_ready  = !hold_full;
  assign stuff_now = (st == TX_DATA || st == TX_FCS) && (ones == STUFF_RUN);
  assign crc_nx    = crc_step(crc, sreg[0]);

  always_comb begin
    case (st)
      TX_FLAG:  dbit = FLAG_BYTE[bcnt[2:0]];
      TX_DATA:  dbit = stuff_now ? 1'b0 : sreg[0];
      TX_FCS:   dbit = stuff_now ? 1'b0 : fcs[0];
      default:  dbit = 1'b1;
    endcase
    ones_nx = dbit ? ones + 3'd1 : 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_FLAG; bcnt <= '0; ones <= '0; sreg <= '0; sreg_last <= 1'b0;
      hold_d <= '0; hold_last <= 1'b0; hold_full <= 1'b0;
      crc <= CRC_PRESET; fcs <= '0;
    end else begin
      if (tx_valid && !hold_full) begin
        hold_d <= tx_data; hold_last <= tx_last; hold_full <= 1'b1;
      end
      if (bit_en) begin
        case (st)
          TX_FLAG: begin
            if (bcnt == BYTE_END) begin
              bcnt <= '0;
              if (hold_full) begin
                sreg <= hold_d; sreg_last <= hold_last; hold_full <= 1'b0;
                crc <= CRC_PRESET; ones <= '0; st <= TX_DATA;
              end
            end else bcnt <= bcnt + 1'b1;
          end
          TX_DATA: begin
            if (stuff_now) ones <= '0;
            else begin
              ones <= ones_nx;
              crc  <= crc_nx;
              sreg <= {1'b0, sreg[BYTE_W-1:1]};
              if (bcnt == BYTE_END) begin
                bcnt <= '0;
                if (sreg_last) begin
                  fcs <= ~crc_nx; st <= TX_FCS;
                end else if (hold_full) begin
                  sreg <= hold_d; sreg_last <= hold_last; hold_full <= 1'b0;
                end else st <= TX_ABORT;
              end else bcnt <= bcnt + 1'b1;
            end
          end
          TX_FCS: begin
            if (stuff_now) begin
              ones <= '0;
              if (bcnt == FCS_TAIL) begin bcnt <= '0; st <= TX_FLAG; end
            end else begin
              ones <= ones_nx;
              fcs  <= {1'b0, fcs[FCS_W-1:1]};
              if (bcnt == FCS_END) begin
                if (ones_nx == STUFF_RUN) bcnt <= FCS_TAIL;
                else begin bcnt <= '0; st <= TX_FLAG; end
              end else bcnt <= bcnt + 1'b1;
            end
          end
          default: begin
            if (bcnt == ABORT_END) begin bcnt <= '0; st <= TX_FLAG; end
            else bcnt <= bcnt + 1'b1;
          end
        endcase
      end
    end
  end

  // R3
  stuff_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_DATA || st == TX_FCS) |-> ones <= STUFF_RUN);

  // R8
  handshake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/sdlc_rx.sv
module sdlc_rx
  import sdlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_line,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_frame_start,
  output logic              rx_frame_end,
  output logic              rx_abort,
  output logic              rx_crc_err,
  output logic              rx_len_err
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  logic              prev, in_sync, in_frame;
  logic [2:0]        rones;
  logic [BW-1:0]     bcnt;
  logic [1:0]        nb;
  logic [BYTE_W-1:0] sh, hold0, hold1;
  logic [FCS_W-1:0]  crc;
  logic              rbit, at_flag, at_abort, at_data, len_bad;
  logic [BYTE_W-1:0] sh_nx;

  always_comb begin
    rbit     = (rx_line == prev);
    at_flag  = !rbit && (rones == FLAG_RUN);
    at_abort = rbit && (rones == FLAG_RUN);
    at_data  = rbit ? (rones < FLAG_RUN) : (rones < STUFF_RUN);
    sh_nx    = {rbit, sh[BYTE_W-1:1]};
    len_bad  = (nb < 2'd2) || (bcnt != BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b1; in_sync <= 1'b0; in_frame <= 1'b0; rones <= '0; bcnt <= '0;
      nb <= '0; sh <= '0; hold0 <= '0; hold1 <= '0; crc <= CRC_PRESET;
      rx_valid <= 1'b0; rx_data <= '0; rx_frame_start <= 1'b0; rx_frame_end <= 1'b0;
      rx_abort <= 1'b0; rx_crc_err <= 1'b0; rx_len_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0; rx_frame_start <= 1'b0; rx_frame_end <= 1'b0;
      rx_abort <= 1'b0; rx_crc_err <= 1'b0; rx_len_err <= 1'b0;
      if (bit_en) begin
        prev  <= rx_line;
        rones <= rbit ? ((rones == RUN_MAX) ? RUN_MAX : rones + 3'd1) : 3'd0;
        if (at_abort) begin
          rx_abort <= in_frame;
          in_sync  <= 1'b0;
          in_frame <= 1'b0;
        end else if (at_flag) begin
          if (in_frame) begin
            rx_frame_end <= 1'b1;
            rx_len_err   <= len_bad;
            rx_crc_err   <= !len_bad && (crc != CRC_RESIDUE);
          end
          in_sync <= 1'b1; in_frame <= 1'b0;
          bcnt <= '0; nb <= '0; crc <= CRC_PRESET;
        end else if (at_data && in_sync) begin
          sh   <= sh_nx;
          bcnt <= bcnt + 1'b1;
          if (bcnt == BIT_LAST) begin
            crc   <= crc_octet(crc, sh_nx);
            hold0 <= sh_nx;
            hold1 <= hold0;
            if (nb == 2'd0) begin rx_frame_start <= 1'b1; in_frame <= 1'b1; end
            if (nb >= 2'd2) begin rx_data <= hold1; rx_valid <= 1'b1; end
            if (nb != 2'd3) nb <= nb + 2'd1;
          end
        end
      end
    end
  end

  // R6
  abort_end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_abort && rx_frame_end));

  // R5
  crc_err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_err |-> (rx_frame_end && !rx_len_err));
endmodule

// File: rtl/sdlc_bitproc.sv
module sdlc_bitproc
  import sdlc_pkg::*;
#(
  parameter int ABORT_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_last,
  output logic              tx_line,
  input  logic              rx_line,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_frame_start,
  output logic              rx_frame_end,
  output logic              rx_abort,
  output logic              rx_crc_err,
  output logic              rx_len_err
);
  logic tx_dbit;

  sdlc_tx #(.ABORT_BITS(ABORT_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .dbit(tx_dbit)
  );

  // NRZI encoder: a zero flips the line
  always_ff @(posedge clk) begin
    if (!rst_n) tx_line <= 1'b1;
    else if (bit_en && !tx_dbit) tx_line <= ~tx_line;
  end

  sdlc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_line(rx_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_start(rx_frame_start),
    .rx_frame_end(rx_frame_end), .rx_abort(rx_abort), .rx_crc_err(rx_crc_err),
    .rx_len_err(rx_len_err)
  );

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_line) && !rx_valid && !rx_frame_end));
endmodule

// File: tb/sdlc_bitproc_bench.sv
`timescale 1ns/1ps
module sdlc_bitproc_bench;
  logic clk = 0, rst_n = 0, bit_en = 0, en_run = 1;
  logic tx_valid = 0, tx_last = 0, bench_line = 1, sel = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, tx_line, rx_valid, rx_frame_start, rx_frame_end, rx_abort, rx_crc_err, rx_len_err;
  logic [7:0] rx_data;
  logic rx_line;
  int div = 0, errors = 0, checks = 0;
  int ng = 0, nend = 0, nstart = 0, nabort = 0, maxrun = 0, run = 0, tones = 0;
  bit last_crc = 0, last_len = 0, done = 0, tx_prev = 1;
  logic [7:0] got [64];
  logic [7:0] pay [16];

  assign rx_line = sel ? bench_line : tx_line;
  always #5 clk = ~clk;

  sdlc_bitproc u_sdlc_bitproc (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_line(tx_line), .rx_line(rx_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_start(rx_frame_start),
    .rx_frame_end(rx_frame_end), .rx_abort(rx_abort), .rx_crc_err(rx_crc_err),
    .rx_len_err(rx_len_err));

  always @(negedge clk) begin
    div <= (div + 1) % 4;
    bit_en <= en_run && (div == 3);
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_valid && ng < 64) begin got[ng] = rx_data; ng++; end
    if (rx_frame_start) nstart++;
    if (rx_frame_end) begin nend++; last_crc = rx_crc_err; last_len = rx_len_err; end
    if (rx_abort) nabort++;
    if (bit_en) begin
      run = (tx_line == tx_prev) ? run + 1 : 0;
      tx_prev = tx_line;
      if (run > maxrun) maxrun = run;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fcs_calc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic x = c[0] ^ pay[i][b];
        c = c >> 1;
        if (x) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic clr();
    ng = 0; nend = 0; nstart = 0; nabort = 0;
  endtask

  task automatic push(input logic [7:0] d, input logic l);
    @(negedge clk); tx_valid = 1; tx_data = d; tx_last = l;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) push(pay[i], i == n - 1);
  endtask

  task automatic wait_done(input int tgt);
    int t = 0;
    while ((nend + nabort) < tgt && t < 6000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    do @(posedge clk); while (!bit_en);
    #1;
    if (!b) bench_line = ~bench_line;
  endtask

  task automatic put_flag();
    put_bit(0); repeat (6) put_bit(1); put_bit(0);
  endtask

  task automatic put_data(input logic b);
    put_bit(b);
    tones = b ? tones + 1 : 0;
    if (tones == 5) begin put_bit(0); tones = 0; end
  endtask

  task automatic put_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) put_data(d[i]);
  endtask

  task automatic raw_frame(input int n, input bit with_fcs, input bit corrupt, input int extra);
    logic [15:0] f;
    f = fcs_calc(n) ^ {15'd0, corrupt};
    put_flag(); tones = 0;
    for (int i = 0; i < n; i++) put_byte(pay[i]);
    if (with_fcs) begin put_byte(f[7:0]); put_byte(f[15:8]); end
    for (int i = 0; i < extra; i++) put_data(0);
    put_flag(); put_flag();
  endtask

  task automatic t_reset();
    chk(tx_line == 1, "R1 reset tx_line", tx_line, 1);
    chk(tx_ready == 1, "R1 reset tx_ready", tx_ready, 1);
    chk(rx_valid == 0 && rx_frame_end == 0, "R1 reset rx strobes", rx_valid, 0);
  endtask

  task automatic t_idle();
    repeat (8) @(negedge clk); maxrun = 0; clr();
    repeat (160) @(negedge clk);
    chk(maxrun == 6, "R4 R1 idle flag run", maxrun, 6);
    chk(nstart == 0 && nend == 0, "R4 idle no frames", nstart, 0);
  endtask

  task automatic t_basic();
    clr();
    pay[0] = 8'h12; pay[1] = 8'hC3; pay[2] = 8'h5A;
    push(pay[0], 0);
    chk(tx_ready == 0, "R8 ready low after handshake", tx_ready, 0);
    push(pay[1], 0); push(pay[2], 1);
    wait_done(1);
    chk(nstart == 1, "R4 frame start", nstart, 1);
    chk(nend == 1 && !last_crc && !last_len, "R5 good frame end", {last_crc, last_len}, 0);
    chk(ng == 3, "R2 byte count", ng, 3);
    for (int i = 0; i < 3; i++) chk(got[i] == pay[i], "R2 loop data", got[i], pay[i]);
  endtask

  task automatic t_stuff();
    clr(); maxrun = 0;
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'hFF; pay[3] = 8'h7E; pay[4] = 8'hFF;
    send_frame(5);
    wait_done(1);
    chk(maxrun == 6, "R3 max ones run", maxrun, 6);
    chk(ng == 5 && !last_crc && !last_len, "R3 stuffed frame ok", ng, 5);
    for (int i = 0; i < 5; i++) chk(got[i] == pay[i], "R3 stuffed data", got[i], pay[i]);
  endtask

  task automatic t_b2b();
    clr();
    pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3; pay[3] = 8'hD4;
    push(pay[0], 0); push(pay[1], 1); push(pay[2], 0); push(pay[3], 1);
    wait_done(2);
    chk(nend == 2 && nabort == 0, "R10 two frame ends", nend, 2);
    chk(ng == 4, "R10 byte count", ng, 4);
    for (int i = 0; i < 4; i++) chk(got[i] == pay[i], "R10 data", got[i], pay[i]);
  endtask

  task automatic t_underrun();
    clr();
    push(8'h3C, 0);
    wait_done(1);
    chk(nabort == 1, "R8 R6 underrun abort", nabort, 1);
    chk(nend == 0 && ng == 0, "R6 no end after abort", nend, 0);
    repeat (100) @(negedge clk);
    clr(); pay[0] = 8'h99; pay[1] = 8'h66;
    send_frame(2); wait_done(1);
    chk(nend == 1 && ng == 2 && got[1] == 8'h66 && !last_crc, "R6 resync after abort", ng, 2);
  endtask

  task automatic t_hold();
    logic l;
    clr(); en_run = 0;
    repeat (8) @(negedge clk);
    l = tx_line;
    push(8'h4D, 1);
    repeat (40) @(negedge clk);
    chk(tx_line == l, "R9 line holds", tx_line, l);
    chk(tx_ready == 0, "R9 byte not consumed", tx_ready, 0);
    en_run = 1;
    wait_done(1);
    chk(ng == 1 && got[0] == 8'h4D && !last_crc, "R9 frame after release", got[0], 8'h4D);
  endtask

  task automatic t_raw();
    @(negedge clk); bench_line = tx_line; sel = 1;
    put_flag(); put_flag(); clr();
    pay[0] = 8'h01; pay[1] = 8'h80; pay[2] = 8'hA5;
    raw_frame(3, 1, 0, 0); wait_done(1);
    chk(nend == 1 && !last_crc && !last_len, "R5 R1 raw good", {last_crc, last_len}, 0);
    chk(ng == 3 && got[0] == 8'h01 && got[1] == 8'h80 && got[2] == 8'hA5, "R2 lsb first",
        got[0], 8'h01);
    clr(); raw_frame(3, 1, 1, 0); wait_done(1);
    chk(nend == 1 && last_crc && !last_len, "R5 bad fcs", last_crc, 1);
    clr();
    put_flag(); tones = 0; put_byte(8'h11); put_byte(8'h22);
    repeat (8) put_bit(1);
    put_flag(); put_flag(); wait_done(1);
    chk(nabort == 1 && nend == 0 && nstart == 1, "R6 raw abort", nabort, 1);
    clr(); pay[0] = 8'h55; raw_frame(1, 0, 0, 0); wait_done(1);
    chk(nend == 1 && last_len && !last_crc, "R7 short frame", last_len, 1);
    clr(); pay[0] = 8'h0F; pay[1] = 8'hF0; raw_frame(2, 1, 0, 3); wait_done(1);
    chk(nend == 1 && last_len, "R7 misaligned frame", last_len, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_stuff();
    t_b2b();
    t_underrun();
    t_hold();
    t_raw();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule